// File: doc/BRIEF.md
# External interrupt request sensing unit

This block takes six active-low external interrupt request pins and turns them into interrupt requests for a CPU. Each pin is brought into the clock domain through a synchroniser. It then drives a per-pin request flag in one of two ways. In level mode, the flag tracks the pin while the pin is held low. In edge mode, a falling edge sets the flag and the flag stays set until software clears it.

Software uses a small register bus with one write strobe and a combinational read path. Through it, software sets which pins may interrupt, chooses the sensing mode of each pin and clears edge flags. The unit drives one request line per pin and a combined line that the CPU's interrupt logic can watch. A standby input returns the unit to its reset configuration.

Top module: `irq_sense`

## Requirements
- R1: After a synchronous active-low reset, the enable register (address 0), the sense register (address 1) and the flag register (address 2) all read 0x00, and `irq` and `irq_any` are 0.
- R2: Reads return all 8 stored bits of the enable and sense registers, including bits 7 and 6. A write with `wr_en` high is stored at the clock edge that samples it and can be read back after that edge.
- R3: When sense bit i (bits 5..0) is 0, pin i is level sensed. Its flag is the inverse of the pin, delayed by three clock edges (two synchroniser flops and the flag register). A request therefore lasts only while the pin stays low.
- R4: When sense bit i is 1, a falling edge on pin i sets flag i three clock edges later. The flag stays set after the pin returns high.
- R5: Writing to address 2 clears each flag whose wdata bit is 1. Bits written as 0 leave their flags unchanged. In level mode the write has no lasting effect, because the flag keeps tracking the pin.
- R6: If a falling edge reaches a flag in the same cycle as a clear of that flag, the flag is set.
- R7: Bits 7 and 6 of the enable and sense registers gate no request and select no sensing mode.
- R8: Flags are recorded whatever the enable bits hold. `irq[i]` is flag i AND enable bit i, and `irq_any` is the OR of the six `irq` bits.
- R9: One clock edge with `stby` high clears the enable register, the sense register and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stby | input | 1 | Hardware standby; clears configuration and flags |
| irq_pin_n | input | 6 | Asynchronous active-low request pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 enable, 1 sense, 2 flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 6 | Per-pin gated requests |
| irq_any | output | 1 | OR of all requests |

## Verification
In level mode, all 64 pin patterns are applied, each held until it settles and once checked before the third edge. This separates a correct mapping and latency from a wrong inversion or a wrong number of synchroniser stages. In edge mode, all 63 non-zero falling patterns are applied and then released. This separates sticky flags from level behaviour, and per-bit clears from whole-register clears. All 64 enable masks are swept with every pin low, together with a flag check while all enables are 0, to confirm that gating follows recording. Two directed cases follow. One lands a clear on the same cycle as an edge. The other configures only bits 7 and 6 and confirms that they have no effect.

// File: rtl/irq_sense_pkg.sv
// Shared widths and register addresses for the interrupt sensing unit.
package irq_sense_pkg;
    localparam int ADDR_W = 2;
    localparam int REG_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_EN   = 2'd0,
        ADDR_SC   = 2'd1,
        ADDR_FLAG = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
// Multi-flop synchroniser for a vector of asynchronous pins.
// Assumes STAGES >= 2. Resets to all ones, the idle level of active-low pins.
module irq_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES];

    // Shift the pin samples through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage[k] <= '1;
        end else begin
            stage[0] <= din;
            for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/irq_pin_cell.sv
// Request flag for one pin.
// Level mode: the flag follows the inverted synchronised input.
// Edge mode: a falling edge sets a sticky flag, and an edge beats a clear
// that arrives in the same cycle. Standby clears the flag.
// Assumes sync_in is already synchronous to clk.
module irq_pin_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic stby,
    input  logic edge_mode,
    input  logic sync_in,
    input  logic clr,
    output logic fall,
    output logic flag
);
    logic prev;

    assign fall = prev & ~sync_in;

    // Keep the previous sample and update the flag for the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b1;
            flag <= 1'b0;
        end else begin
            prev <= sync_in;
            if (stby)            flag <= 1'b0;
            else if (!edge_mode) flag <= ~sync_in;
            else                 flag <= fall | (flag & ~clr);
        end
    end
endmodule

// File: rtl/irq_bus_regs.sv
// Enable and sense registers with the read mux and the clear decode for the
// flag register. Bits above NPINS are plain storage.
// Assumes NPINS <= REG_W.
module irq_bus_regs
    import irq_sense_pkg::*;
#(
    parameter int NPINS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NPINS-1:0]  flags,
    output logic [REG_W-1:0]  en_q,
    output logic [REG_W-1:0]  sc_q,
    output logic [NPINS-1:0]  clr_vec,
    output logic [REG_W-1:0]  rdata
);
    logic [REG_W-1:0] flags_ext;

    // Store register writes; reset and standby return both registers to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || stby) begin
            en_q <= '0;
            sc_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_EN) en_q <= wdata;
            if (addr == ADDR_SC) sc_q <= wdata;
        end
    end

    // Decode a write-one-to-clear on the flag register.
    always_comb begin
        clr_vec = '0;
        if (wr_en && addr == ADDR_FLAG) clr_vec = wdata[NPINS-1:0];
    end

    // Select the read data for the addressed register.
    always_comb begin
        flags_ext = '0;
        flags_ext[NPINS-1:0] = flags;
        case (addr)
            ADDR_EN:   rdata = en_q;
            ADDR_SC:   rdata = sc_q;
            ADDR_FLAG: rdata = flags_ext;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_sense.sv
// Top of the external interrupt sensing unit: synchroniser, per-pin flag
// cells, register block and request gating.
// Assumes the bus is synchronous to clk and the pins are asynchronous.
module irq_sense
    import irq_sense_pkg::*;
#(
    parameter int NPINS       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby,
    input  logic [NPINS-1:0]  irq_pin_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [NPINS-1:0]  irq,
    output logic              irq_any
);
    logic [NPINS-1:0] sync_now;
    logic [NPINS-1:0] fall_vec;
    logic [NPINS-1:0] flags;
    logic [NPINS-1:0] clr_vec;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] sc_q;

    irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(irq_pin_n), .dout(sync_now)
    );

    irq_bus_regs #(.NPINS(NPINS)) i_regs (
        .clk(clk), .rst_n(rst_n), .stby(stby), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .flags(flags), .en_q(en_q), .sc_q(sc_q),
        .clr_vec(clr_vec), .rdata(rdata)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        irq_pin_cell i_cell (
            .clk(clk), .rst_n(rst_n), .stby(stby), .edge_mode(sc_q[i]),
            .sync_in(sync_now[i]), .clr(clr_vec[i]),
            .fall(fall_vec[i]), .flag(flags[i])
        );
    end

    // Gate each flag with its enable bit and combine the requests.
    always_comb begin
        irq     = flags & en_q[NPINS-1:0];
        irq_any = |irq;
    end
endmodule

// File: rtl/irq_sense_chk.sv
// Assertion checker for irq_sense, bound to every instance of the top.
module irq_sense_chk
    import irq_sense_pkg::*;
#(
    parameter int NPINS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stby,
    input logic              wr_en,
    input logic [REG_W-1:0]  en_q,
    input logic [REG_W-1:0]  sc_q,
    input logic [NPINS-1:0]  flags,
    input logic [NPINS-1:0]  sync_now,
    input logic [NPINS-1:0]  fall_vec,
    input logic              irq_any
);
    // R3: a level-sensed flag is the inverse of the previous synchronised sample.
    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby && !wr_en) |=>
        ((~sc_q[NPINS-1:0] & (flags ^ ~$past(sync_now))) == '0));

    // R4: with no bus write and no standby, an edge-mode flag stays set.
    p_edge_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby && !wr_en) |=>
        ((($past(flags) & sc_q[NPINS-1:0]) & ~flags) == '0));

    // R6: a detected edge in edge mode always sets its flag, even under a clear.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stby |=>
        ((($past(fall_vec) & $past(sc_q[NPINS-1:0])) & ~flags) == '0));

    // R8: the combined request needs at least one enabled flag.
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (|(flags & en_q[NPINS-1:0])));

    // R9: standby leaves configuration and flags cleared.
    p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stby |=> (en_q == '0 && sc_q == '0 && flags == '0));
endmodule

bind irq_sense irq_sense_chk #(.NPINS(NPINS)) i_chk (.*);

// File: tb/test_irq_sense.sv
module test_irq_sense;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stby = 1'b0;
    logic [5:0] irq_pin_n = 6'h3F;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [5:0] irq;
    logic       irq_any;

    int checks = 0;
    int errors = 0;

    irq_sense i_irq_sense (
        .clk(clk), .rst_n(rst_n), .stby(stby), .irq_pin_n(irq_pin_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .irq_any(irq_any)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        bus_rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic chk_irq(input string tag, input logic [5:0] exp);
        chk(tag, {2'b00, irq}, {2'b00, exp});
        chk(tag, {7'd0, irq_any}, {7'd0, exp != 6'd0});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk_reg("R1 enable", 2'd0, 8'h00);
        chk_reg("R1 sense", 2'd1, 8'h00);
        chk_reg("R1 flags", 2'd2, 8'h00);
        chk_irq("R1 irq", 6'h00);

        // R2: full 8-bit read back of both registers
        for (int v = 0; v < 256; v++) begin
            bus_wr(2'd0, 8'(v));
            chk_reg("R2 enable readback", 2'd0, 8'(v));
            bus_wr(2'd1, 8'(v));
            chk_reg("R2 sense readback", 2'd1, 8'(v));
        end

        // R3: level sweep, including latency
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'h3F);
        irq_pin_n = 6'h3F;
        tick(3);
        for (int p = 0; p < 64; p++) begin
            logic [5:0] prev_req;
            prev_req = ~irq_pin_n;
            irq_pin_n = 6'(p);
            tick(2);
            chk_irq("R3 level before latency", prev_req);
            tick();
            chk_irq("R3 level pattern", ~6'(p));
        end

        // R5: a clear in level mode does not stick
        irq_pin_n = 6'h00;
        tick(3);
        bus_wr(2'd2, 8'h3F);
        chk_reg("R5 level clear ignored", 2'd2, 8'h3F);

        // R8: enable sweep with every pin low
        for (int e = 0; e < 64; e++) begin
            bus_wr(2'd0, 8'(e));
            chk_irq("R8 enable gating", 6'(e));
        end

        // R4 and R5: edge sweep with sticky flags and a per-bit clear
        irq_pin_n = 6'h3F;
        tick(3);
        bus_wr(2'd0, 8'h3F);
        bus_wr(2'd1, 8'h3F);
        for (int p = 1; p < 64; p++) begin
            irq_pin_n = ~6'(p);
            tick(3);
            irq_pin_n = 6'h3F;
            tick(3);
            chk_reg("R4 sticky flags", 2'd2, 8'(p));
            chk_irq("R4 edge request", 6'(p));
            bus_wr(2'd2, 8'(p));
            chk_reg("R5 clear all set", 2'd2, 8'h00);
        end

        // R5: partial clear and a write of zero
        irq_pin_n = 6'h00;
        tick(3);
        irq_pin_n = 6'h3F;
        tick(3);
        bus_wr(2'd2, 8'h15);
        chk_reg("R5 partial clear", 2'd2, 8'h2A);
        bus_wr(2'd2, 8'h00);
        chk_reg("R5 zero write", 2'd2, 8'h2A);
        bus_wr(2'd2, 8'h3F);

        // R6: an edge coinciding with a clear sets the flag
        irq_pin_n = 6'h3E;
        tick(2);
        bus_wr(2'd2, 8'h01);
        chk_reg("R6 set wins", 2'd2, 8'h01);
        irq_pin_n = 6'h3F;
        tick(3);
        bus_wr(2'd2, 8'h3F);

        // R8: flags recorded while all enables are off
        bus_wr(2'd0, 8'h00);
        irq_pin_n = 6'h00;
        tick(3);
        irq_pin_n = 6'h3F;
        tick(3);
        chk_reg("R8 flags while disabled", 2'd2, 8'h3F);
        chk_irq("R8 no request while disabled", 6'h00);
        bus_wr(2'd0, 8'h3F);
        chk_irq("R8 request after enable", 6'h3F);
        bus_wr(2'd2, 8'h3F);

        // R7: bits 7 and 6 neither select edge mode nor enable a request
        bus_wr(2'd1, 8'hC0);
        bus_wr(2'd0, 8'hC0);
        irq_pin_n = 6'h00;
        tick(3);
        chk_irq("R7 reserved enable", 6'h00);
        bus_wr(2'd0, 8'hFF);
        chk_irq("R7 level with reserved sense", 6'h3F);
        irq_pin_n = 6'h3F;
        tick(3);
        chk_irq("R7 not sticky", 6'h00);

        // R9: standby clears configuration and flags
        bus_wr(2'd1, 8'h00);
        irq_pin_n = 6'h00;
        tick(3);
        chk_irq("R9 before standby", 6'h3F);
        stby = 1'b1;
        tick();
        stby = 1'b0;
        chk_reg("R9 enable", 2'd0, 8'h00);
        chk_reg("R9 sense", 2'd1, 8'h00);
        chk_reg("R9 flags", 2'd2, 8'h00);
        chk_irq("R9 irq", 6'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule